// File: doc/BRIEF.md
# Sliding Integral-Image Window Array

This block holds the integral image of one square subwindow as a WIN×WIN array of values (24×24 by default, 18 bits each). Element (r,c) holds the sum of all pixels of the subwindow in rows 0..r and columns 0..c. The array is fed one row at a time. Each row arrives as a vector of cumulative line sums: entry c is the sum of that image row's pixels from the subwindow's left edge through column c. Subwindows are visited top to bottom within one column position, and column positions advance left to right.

A row that arrives together with the column-start flag begins a fresh vertical scan. During the first WIN rows the array fills: the bottom line adds each incoming row to its running total and every other line takes the value of the line below it. After that, every further row moves the subwindow down one pixel row. In that sliding update, each upper line becomes the line below it minus the current top line. The bottom line becomes itself plus the new row minus the current top line.

A small controller has three states. ST_IDLE is entered at reset. ST_FILL is entered by the *start* transition, which is any accepted row carrying the column-start flag and is taken from every state. ST_SLIDE is entered by the *fill_done* transition when the WIN-th row of a fill is accepted. In ST_IDLE, rows without the flag are ignored. Four combinational read ports return elements for rectangle-sum evaluation, and the bottom-right corner value is also driven on a port of its own.

Top module: `integral_window_array`

## Requirements
- R1: After reset, window_valid is 0 and every element (and therefore corner and every read port) reads 0.
- R2: A row accepted (row_valid=1) with col_start=1 starts a fill. After WIN accepted rows, element (r,c) equals the sum of entry c of the first r+1 rows of the scan.
- R3: window_valid stays 0 while fewer than WIN rows of the current fill have been accepted. It is 1 from the cycle after the WIN-th row and stays 1 across sliding updates.
- R4: When window_valid is 1, a row accepted with col_start=0 moves the subwindow down one row. Afterwards element (r,c) equals the sum of entry c over the latest WIN rows, taken oldest first through row r.
- R5: In a cycle with row_valid=0 the array and window_valid keep their values.
- R6: A row with col_start=0 accepted in ST_IDLE (no fill ever started since reset) changes nothing: the elements stay 0 and window_valid stays 0.
- R7: A row with col_start=1 during a fill or a slide restarts the fill. window_valid is 0 in the next cycle, earlier content is discarded, and after WIN rows the array matches the new scan only.
- R8: Read port p takes a row index at rd_row[p*RW +: RW] and a column index at rd_col[p*RW +: RW], with RW=$clog2(WIN). It returns element (row,col) combinationally at rd_data[p*IW +: IW]. An index of WIN or above on either coordinate returns 0.
- R9: corner always equals element (WIN-1, WIN-1).
- R10: Entry c of the incoming row sits at cls_row[c*IW +: IW]. All arithmetic wraps modulo 2^IW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | A cumulative-line-sum row is presented this cycle |
| col_start | input | 1 | The presented row is the top row of a new vertical scan |
| cls_row | input | WIN*IW | Cumulative line sums, entry c at bits c*IW |
| rd_row | input | NRP*RW | Row index per read port |
| rd_col | input | NRP*RW | Column index per read port |
| rd_data | output | NRP*IW | Element value per read port |
| window_valid | output | 1 | Array holds a complete subwindow integral |
| corner | output | IW | Element (WIN-1, WIN-1) |

## Verification
The bench builds a pseudo-random 36×30 image. It scans several column offsets through full heights and compares all elements against sums recomputed from the pixels at every subwindow position. This separates errors in the fill path (the first position) from errors in the subtract-and-shift path (later positions) and from per-column mistakes. One scan inserts idle cycles between rows, which exposes any drift while the array is holding. A short scan is followed by a restart, and a later restart lands in the middle of sliding. Together these tell a clean restart apart from leftover state. Directed cases cover a flagless row straight after reset and out-of-range read indices.

// File: rtl/iwa_pkg.sv
`timescale 1ns/1ps
package iwa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_SLIDE = 2'd2
    } iwa_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_ACCUM = 2'd2,
        OP_SLIDE = 2'd3
    } cell_op_e;
endpackage

// File: rtl/iwa_ctrl.sv
`timescale 1ns/1ps
module iwa_ctrl
    import iwa_pkg::*;
#(
    parameter int WIN = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     row_valid,
    input  logic     col_start,
    output cell_op_e op,
    output logic     window_valid
);
    localparam int CW = $clog2(WIN);
    localparam logic [CW-1:0] LAST_ROW = CW'(WIN - 1);

    iwa_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (row_valid && col_start) begin
            state_d = ST_FILL;
            cnt_d   = CW'(1);
        end else if (row_valid) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FILL: begin
                    if (cnt_q == LAST_ROW) begin
                        state_d = ST_SLIDE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_SLIDE: state_d = ST_SLIDE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        op           = OP_HOLD;
        window_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  window_valid = 1'b0;
            ST_FILL:  window_valid = 1'b0;
            ST_SLIDE: window_valid = 1'b1;
            default:  window_valid = 1'b0;
        endcase
        if (row_valid && col_start) begin
            op = OP_LOAD;
        end else if (row_valid) begin
            unique case (state_q)
                ST_IDLE:  op = OP_HOLD;
                ST_FILL:  op = OP_ACCUM;
                ST_SLIDE: op = OP_SLIDE;
                default:  op = OP_HOLD;
            endcase
        end
    end

    AST_RESTART_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && col_start) |=> !window_valid); // R7
    AST_VALID_RISES_ON_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_valid) |-> $past(row_valid && !col_start)); // R3
    AST_ORPHAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && row_valid && !col_start) |=> (state_q == ST_IDLE)); // R6
    AST_SLIDE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (window_valid && !(row_valid && col_start)) |=> window_valid); // R3
endmodule

// File: rtl/iwa_cell.sv
`timescale 1ns/1ps
module iwa_cell
    import iwa_pkg::*;
#(
    parameter int IW     = 18,
    parameter bit BOTTOM = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cell_op_e      op,
    input  logic [IW-1:0] below,
    input  logic [IW-1:0] top,
    output logic [IW-1:0] q
);
    logic [IW-1:0] d;

    generate
        if (BOTTOM) begin : g_acc
            always_comb begin
                unique case (op)
                    OP_HOLD:  d = q;
                    OP_LOAD:  d = below;
                    OP_ACCUM: d = q + below;
                    OP_SLIDE: d = q + below - top;
                    default:  d = q;
                endcase
            end
        end else begin : g_shift
            always_comb begin
                unique case (op)
                    OP_HOLD:  d = q;
                    OP_LOAD:  d = below;
                    OP_ACCUM: d = below;
                    OP_SLIDE: d = below - top;
                    default:  d = q;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q)); // R5
endmodule

// File: rtl/iwa_read_mux.sv
`timescale 1ns/1ps
module iwa_read_mux #(
    parameter int WIN = 24,
    parameter int IW  = 18,
    parameter int NRP = 4,
    parameter int RW  = 5
) (
    input  logic [WIN*WIN*IW-1:0] win_flat,
    input  logic [NRP*RW-1:0]     rd_row,
    input  logic [NRP*RW-1:0]     rd_col,
    output logic [NRP*IW-1:0]     rd_data
);
    generate
        for (genvar p = 0; p < NRP; p++) begin : g_port
            logic [RW-1:0] r_i, c_i;
            logic [IW-1:0] val;
            assign r_i = rd_row[p*RW +: RW];
            assign c_i = rd_col[p*RW +: RW];
            always_comb begin
                val = '0;
                if (int'(r_i) < WIN && int'(c_i) < WIN)
                    val = win_flat[(int'(r_i) * WIN + int'(c_i)) * IW +: IW];
            end
            assign rd_data[p*IW +: IW] = val;
        end
    endgenerate
endmodule

// File: rtl/integral_window_array.sv
`timescale 1ns/1ps
module integral_window_array
    import iwa_pkg::*;
#(
    parameter int   WIN = 24,
    parameter int   IW  = 18,
    parameter int   NRP = 4,
    localparam int  RW  = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_valid,
    input  logic              col_start,
    input  logic [WIN*IW-1:0] cls_row,
    input  logic [NRP*RW-1:0] rd_row,
    input  logic [NRP*RW-1:0] rd_col,
    output logic [NRP*IW-1:0] rd_data,
    output logic              window_valid,
    output logic [IW-1:0]     corner
);
    localparam int NEL    = WIN * WIN;
    localparam int CORNER = NEL - 1;

    cell_op_e              op;
    logic [NEL*IW-1:0]     win_flat;

    iwa_ctrl #(.WIN(WIN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .row_valid    (row_valid),
        .col_start    (col_start),
        .op           (op),
        .window_valid (window_valid)
    );

    generate
        for (genvar r = 0; r < WIN; r++) begin : g_row
            for (genvar c = 0; c < WIN; c++) begin : g_col
                logic [IW-1:0] below_v;
                if (r == WIN - 1) begin : g_feed
                    assign below_v = cls_row[c*IW +: IW];
                end else begin : g_link
                    assign below_v = win_flat[((r+1)*WIN + c)*IW +: IW];
                end
                iwa_cell #(.IW(IW), .BOTTOM(r == WIN - 1)) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .op    (op),
                    .below (below_v),
                    .top   (win_flat[c*IW +: IW]),
                    .q     (win_flat[(r*WIN + c)*IW +: IW])
                );
            end
        end
    endgenerate

    iwa_read_mux #(.WIN(WIN), .IW(IW), .NRP(NRP), .RW(RW)) u_rd (
        .win_flat (win_flat),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .rd_data  (rd_data)
    );

    assign corner = win_flat[CORNER*IW +: IW];

    AST_HOLD_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |=> $stable(corner)); // R5
    AST_PORT0_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_row[0 +: RW]) == WIN - 1 && int'(rd_col[0 +: RW]) == WIN - 1)
        |-> (rd_data[0 +: IW] == corner)); // R9
    AST_SLIDE_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (window_valid && row_valid && !col_start) |=>
        (corner == IW'($past(corner) + $past(cls_row[(WIN-1)*IW +: IW])
                      - $past(win_flat[(WIN-1)*IW +: IW])))); // R4
    AST_LOAD_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && col_start) |=> (corner == $past(cls_row[(WIN-1)*IW +: IW]))); // R2
endmodule

// File: tb/integral_window_array_bench.sv
`timescale 1ns/1ps
module integral_window_array_bench;
    localparam int WIN   = 24;
    localparam int IW    = 18;
    localparam int NRP   = 4;
    localparam int RW    = $clog2(WIN);
    localparam int IMG_H = 36;
    localparam int IMG_W = 30;

    // scan table: {x0[5:0], rows[5:0], gap, expected final window_valid}
    localparam int NSCAN = 6;
    localparam logic [13:0] SCANS [NSCAN] = '{
        {6'd0, 6'd36, 1'b0, 1'b1},
        {6'd3, 6'd36, 1'b1, 1'b1},
        {6'd6, 6'd30, 1'b0, 1'b1},
        {6'd5, 6'd10, 1'b0, 1'b0},
        {6'd2, 6'd24, 1'b1, 1'b1},
        {6'd1, 6'd36, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              row_valid = 1'b0;
    logic              col_start = 1'b0;
    logic [WIN*IW-1:0] cls_row = '0;
    logic [NRP*RW-1:0] rd_row = '0;
    logic [NRP*RW-1:0] rd_col = '0;
    logic [NRP*IW-1:0] rd_data;
    logic              window_valid;
    logic [IW-1:0]     corner;

    logic [7:0] img [IMG_H][IMG_W];
    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    integral_window_array #(.WIN(WIN), .IW(IW), .NRP(NRP)) u_integral_window_array (
        .clk (clk), .rst_n (rst_n), .row_valid (row_valid), .col_start (col_start),
        .cls_row (cls_row), .rd_row (rd_row), .rd_col (rd_col), .rd_data (rd_data),
        .window_valid (window_valid), .corner (corner)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cls_val(input int y, input int x0, input int c);
        int s = 0;
        for (int k = 0; k <= c; k++) s += img[y][x0 + k];
        return s;
    endfunction

    function automatic logic [IW-1:0] exp_elem(input int x0, input int y0, input int r, input int c);
        int s = 0;
        for (int k = 0; k <= r; k++) s += cls_val(y0 + k, x0, c);
        return IW'(s);
    endfunction

    // R10: entry c at cls_row[c*IW +: IW]
    task automatic send_row(input int y, input int x0, input bit start, input bit gap);
        if (gap) repeat (3) @(negedge clk);
        @(negedge clk);
        for (int c = 0; c < WIN; c++) cls_row[c*IW +: IW] = IW'(cls_val(y, x0, c));
        row_valid = 1'b1;
        col_start = start;
        @(negedge clk);
        row_valid = 1'b0;
        col_start = 1'b0;
        cls_row   = '0;
    endtask

    // R8: compare every element through the four read ports
    task automatic check_window(input int x0, input int y0, input bit zero, input string tag);
        int bad = 0;
        longint first_act = 0, first_exp = 0;
        for (int e = 0; e < WIN*WIN; e += NRP) begin
            for (int p = 0; p < NRP; p++) begin
                rd_row[p*RW +: RW] = RW'((e + p) / WIN);
                rd_col[p*RW +: RW] = RW'((e + p) % WIN);
            end
            #1;
            for (int p = 0; p < NRP; p++) begin
                logic [IW-1:0] ex;
                ex = zero ? '0 : exp_elem(x0, y0, (e + p) / WIN, (e + p) % WIN);
                if (rd_data[p*IW +: IW] != ex) begin
                    if (bad == 0) begin
                        first_act = rd_data[p*IW +: IW];
                        first_exp = ex;
                    end
                    bad++;
                end
            end
        end
        chk(bad == 0, tag, first_act, first_exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5678;
        for (int y = 0; y < IMG_H; y++)
            for (int x = 0; x < IMG_W; x++) begin
                seed = seed * 32'd1103515245 + 32'd12345;
                img[y][x] = seed[23:16];
            end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(window_valid == 1'b0, "R1 valid after reset", window_valid, 0);
        chk(corner == '0, "R1 corner after reset", corner, 0);
        check_window(0, 0, 1'b1, "R1 elements zero after reset");

        // R6 flagless row in idle
        send_row(5, 2, 1'b0, 1'b0);
        chk(window_valid == 1'b0, "R6 valid after orphan row", window_valid, 0);
        check_window(0, 0, 1'b1, "R6 elements untouched by orphan row");

        // table-driven scans: R2 R3 R4 R5 R7
        for (int i = 0; i < NSCAN; i++) begin
            int x0, nr;
            bit gap, ev;
            x0  = int'(SCANS[i][13:8]);
            nr  = int'(SCANS[i][7:2]);
            gap = SCANS[i][1];
            ev  = SCANS[i][0];
            for (int y = 0; y < nr; y++) begin
                send_row(y, x0, y == 0, gap);
                if (y < WIN - 1) begin
                    chk(window_valid == 1'b0, "R3 valid low during fill", window_valid, 0);
                end else begin
                    chk(window_valid == 1'b1, "R3 valid high after fill", window_valid, 1);
                    if (gap) repeat (2) @(negedge clk); // R5 hold across idle cycles
                    check_window(x0, y - (WIN - 1), 1'b0,
                                 (y == WIN - 1) ? "R2 filled window" : "R4 slid window");
                    chk(corner == exp_elem(x0, y - (WIN - 1), WIN - 1, WIN - 1),
                        "R9 corner", corner, exp_elem(x0, y - (WIN - 1), WIN - 1, WIN - 1));
                end
            end
            chk(window_valid == ev, "R7 valid at scan end", window_valid, ev);
        end

        // R7 restart in the middle of sliding
        send_row(0, 4, 1'b1, 1'b0);
        chk(window_valid == 1'b0, "R7 valid drops on restart", window_valid, 0);
        for (int y = 1; y < WIN; y++) send_row(y, 4, 1'b0, 1'b0);
        chk(window_valid == 1'b1, "R7 valid after refill", window_valid, 1);
        check_window(4, 0, 1'b0, "R7 window after restart");

        // R8 out-of-range indices
        rd_row = '0; rd_col = '0;
        rd_row[0 +: RW] = RW'(WIN);     rd_col[0 +: RW] = RW'(5);
        rd_row[RW +: RW] = RW'(3);      rd_col[RW +: RW] = RW'(31);
        rd_row[2*RW +: RW] = RW'(WIN-1); rd_col[2*RW +: RW] = RW'(WIN-1);
        rd_row[3*RW +: RW] = RW'(0);    rd_col[3*RW +: RW] = RW'(0);
        #1;
        chk(rd_data[0 +: IW] == '0, "R8 row out of range", rd_data[0 +: IW], 0);
        chk(rd_data[IW +: IW] == '0, "R8 col out of range", rd_data[IW +: IW], 0);
        chk(rd_data[2*IW +: IW] == corner, "R9 corner equals port", rd_data[2*IW +: IW], corner);
        chk(rd_data[3*IW +: IW] == IW'(img[0][4]), "R8 origin element",
            rd_data[3*IW +: IW], img[0][4]);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule